// File: doc/BRIEF.md
# Two-Level Vectored Interrupt Controller

This block sits beside a small processor core and decides when the core must leave its current program to service an interrupt, and where it must jump. Six request flags come in from the rest of the chip: two external lines, two basic timers, a combined serial flag and a combined second-timer flag. The block registers an enable mask, a global enable and a priority mask. It samples the flags once per machine cycle and polls the sampled set on the next machine cycle. Among the eligible requests it picks one, and it then holds a call request towards the core for the two machine cycles of the hardware call, with the vector address.

Polling follows what the core reports. The core marks the final cycle of each instruction and flags any instruction that is a return-from-interrupt or a write to the enable or priority register. The block keeps one in-service bit for each priority level. These bits decide whether a new request may preempt the running service routine, and a return-from-interrupt clears the topmost one. When a call is accepted, the block pulses an acknowledge carrying the winning source index. It also pulses a clear towards the flag of that source, but only for the four sources whose flags hardware clears.

The control is a three-state machine. In `IDLE` the core runs code and polling is active. An accepted request moves it IDLE→CALL1. The next machine-cycle strobe moves it CALL1→CALL2, and the one after that moves it CALL2→IDLE. While the state is CALL1 or CALL2, `call_req` is high.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After reset, `call_req`, `ack_valid`, `flag_clr` and `svc_level` are zero and `vec_addr` is 0000h. The enable mask, the global enable and the priority mask reset to zero.
- R2: Source index i is numbered 0 external-0, 1 timer-0, 2 external-1, 3 timer-1, 4 serial, 5 timer-2. It uses bit i of the enable write data and bit i of the priority write data, and bit 7 of the enable data is the global enable. A source can be accepted only when its own bit and the global bit are both 1. A flag that is set while its source is disabled is still sampled but causes no call.
- R3: A flag value present at a machine-cycle strobe is sampled at that strobe and is first considered at the following strobe.
- R4: A request is accepted only at a strobe where `instr_last` is 1, where neither `reti_exec` nor a register write strobe is active, and where the previous completed instruction was not a return or register write.
- R5: A high-priority request (priority bit 1) wins over a low-priority one. Within one level, the lowest source index wins.
- R6: A high-priority request is accepted only when no high-level routine is in service. A low-priority request is accepted only when no routine is in service.
- R7: A strobe with `instr_last` and `reti_exec` both 1 in IDLE clears `svc_level[1]` if it is set, and otherwise clears `svc_level[0]`.
- R8: `call_req` rises on the clock after acceptance and stays high for exactly two machine-cycle strobes. While it is high, `vec_addr` equals 0003h + 8 × source index.
- R9: `ack_valid` is a single-clock pulse on the clock after acceptance, with `ack_src` giving the winning index.
- R10: Together with `ack_valid`, `flag_clr` pulses bit i for a winner i of 0 to 3. For the serial (4) and timer-2 (5) sources it stays zero.
- R11: While `call_req` is high, `instr_last` and `reti_exec` have no effect on the in-service bits or on polling. Register writes still take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mc_tick | input | 1 | Machine-cycle strobe, one clock wide |
| instr_last | input | 1 | Current machine cycle is the final cycle of the instruction |
| reti_exec | input | 1 | Executing instruction is a return-from-interrupt |
| en_wr | input | 1 | Write strobe for the enable register (with `mc_tick`) |
| en_wdata | input | 8 | Enable data: bit 7 global, bits 5..0 per source |
| pri_wr | input | 1 | Write strobe for the priority register (with `mc_tick`) |
| pri_wdata | input | 8 | Priority data: bits 5..0 per source, 1 = high |
| flag_in | input | 6 | Raw request flags, index as in R2 |
| call_req | output | 1 | Hardware call in progress |
| vec_addr | output | 16 | Vector address of the accepted source |
| ack_valid | output | 1 | One-clock acknowledge pulse |
| ack_src | output | 3 | Index of the accepted source |
| flag_clr | output | 6 | One-clock hardware clear pulse per source |
| svc_level | output | 2 | In-service bits, [1] high level, [0] low level |

## Verification
The bench builds the block with its default parameters: six sources, an 8-bit register width, global enable at bit 7, a vector base of 3 with a step of 8, and the lower four sources hardware-cleared. These values give both flag-clearing groups, both priority levels and every vector slot. Nested high-over-low service can occur, and so can calls that land while a return or a register write is still holding polling off. Random traffic mixes flags, enable and priority changes, non-final cycles and returns. Directed sequences pin down the single-machine-cycle sampling delay and the ignored inputs during a call.

// File: rtl/irqv_pkg.sv
`timescale 1ns/1ps
package irqv_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_CALL1 = 2'd1,
        ST_CALL2 = 2'd2
    } call_st_e;

    localparam int LVL_LO = 0;
    localparam int LVL_HI = 1;
endpackage

// File: rtl/irqv_gate.sv
`timescale 1ns/1ps
module irqv_gate #(
    parameter int NSRC = 6
) (
    input  logic [NSRC-1:0] pend,
    input  logic [NSRC-1:0] en_src,
    input  logic [NSRC-1:0] pri,
    input  logic            glb_en,
    output logic [NSRC-1:0] req_hi,
    output logic [NSRC-1:0] req_lo
);
    for (genvar g = 0; g < NSRC; g++) begin : g_src
        logic live;
        assign live      = pend[g] & en_src[g] & glb_en;
        assign req_hi[g] = live & pri[g];
        assign req_lo[g] = live & ~pri[g];
    end
endmodule

// File: rtl/irqv_pick.sv
`timescale 1ns/1ps
module irqv_pick #(
    parameter int NSRC  = 6,
    parameter int IDX_W = $clog2(NSRC)
) (
    input  logic [NSRC-1:0]  req,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    always_comb begin
        any = |req;
        idx = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (req[i]) begin
                idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/irqv_svc.sv
`timescale 1ns/1ps
module irqv_svc (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       set_hi,
    input  logic       set_lo,
    input  logic       reti_clr,
    output logic [1:0] svc
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            svc <= 2'b00;
        end else begin
            if (reti_clr) begin
                if (svc[1]) begin
                    svc[1] <= 1'b0;
                end else begin
                    svc[0] <= 1'b0;
                end
            end
            if (set_hi) begin
                svc[1] <= 1'b1;
            end
            if (set_lo) begin
                svc[0] <= 1'b1;
            end
        end
    end

    AST_LO_NEEDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        set_lo |-> (svc == 2'b00)); // R6
    AST_HI_NOT_NESTED: assert property (@(posedge clk) disable iff (!rst_n)
        set_hi |-> !svc[1]); // R6
    AST_RETI_TOP: assert property (@(posedge clk) disable iff (!rst_n)
        (reti_clr && svc[1]) |=> !svc[1]); // R7
    AST_RETI_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (reti_clr && svc == 2'b01) |=> (svc == 2'b00)); // R7
endmodule

// File: rtl/irq_vector_ctrl.sv
`timescale 1ns/1ps
module irq_vector_ctrl
    import irqv_pkg::*;
#(
    parameter int NSRC      = 6,
    parameter int ADDR_W    = 16,
    parameter int REG_W     = 8,
    parameter int GLB_BIT   = 7,
    parameter int VEC_BASE  = 3,
    parameter int VEC_STEP  = 8,
    parameter int HWCLR_CNT = 4,
    localparam int IDX_W    = $clog2(NSRC)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mc_tick,
    input  logic              instr_last,
    input  logic              reti_exec,
    input  logic              en_wr,
    input  logic [REG_W-1:0]  en_wdata,
    input  logic              pri_wr,
    input  logic [REG_W-1:0]  pri_wdata,
    input  logic [NSRC-1:0]   flag_in,
    output logic              call_req,
    output logic [ADDR_W-1:0] vec_addr,
    output logic              ack_valid,
    output logic [IDX_W-1:0]  ack_src,
    output logic [NSRC-1:0]   flag_clr,
    output logic [1:0]        svc_level
);
    call_st_e          state_q, state_d;
    logic [NSRC-1:0]   pend_q, en_src_q, pri_q;
    logic              ea_q, blk_q;
    logic [NSRC-1:0]   req_hi, req_lo, clr_d;
    logic              hi_any, lo_any, special, poll_ok;
    logic              take_hi, take_lo, accept, reti_clr;
    logic [IDX_W-1:0]  hi_idx, lo_idx, win_idx;
    logic [ADDR_W-1:0] vec_q;
    logic              ack_q;
    logic [IDX_W-1:0]  src_q;
    logic [NSRC-1:0]   clr_q;
    logic              unused_bits;

    assign unused_bits = ^{en_wdata[GLB_BIT-1:NSRC], pri_wdata[REG_W-1:NSRC]};

    // register file and request sampling
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q   <= '0;
            en_src_q <= '0;
            ea_q     <= 1'b0;
            pri_q    <= '0;
        end else if (mc_tick) begin
            pend_q <= flag_in;
            if (en_wr) begin
                en_src_q <= en_wdata[NSRC-1:0];
                ea_q     <= en_wdata[GLB_BIT];
            end
            if (pri_wr) begin
                pri_q <= pri_wdata[NSRC-1:0];
            end
        end
    end

    irqv_gate #(.NSRC(NSRC)) u_gate (
        .pend   (pend_q),
        .en_src (en_src_q),
        .pri    (pri_q),
        .glb_en (ea_q),
        .req_hi (req_hi),
        .req_lo (req_lo)
    );

    irqv_pick #(.NSRC(NSRC), .IDX_W(IDX_W)) u_pick_hi (
        .req (req_hi),
        .any (hi_any),
        .idx (hi_idx)
    );

    irqv_pick #(.NSRC(NSRC), .IDX_W(IDX_W)) u_pick_lo (
        .req (req_lo),
        .any (lo_any),
        .idx (lo_idx)
    );

    // poll gating and level arbitration
    assign special  = reti_exec | en_wr | pri_wr;
    assign poll_ok  = mc_tick && (state_q == ST_IDLE) && instr_last && !special && !blk_q;
    assign take_hi  = poll_ok && hi_any && !svc_level[LVL_HI];
    assign take_lo  = poll_ok && !take_hi && lo_any && (svc_level == 2'b00);
    assign accept   = take_hi | take_lo;
    assign win_idx  = take_hi ? hi_idx : lo_idx;
    assign reti_clr = mc_tick && (state_q == ST_IDLE) && instr_last && reti_exec;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            blk_q <= 1'b0;
        end else if (mc_tick && (state_q == ST_IDLE) && instr_last) begin
            blk_q <= special;
        end
    end

    irqv_svc u_svc (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_hi   (take_hi),
        .set_lo   (take_lo),
        .reti_clr (reti_clr),
        .svc      (svc_level)
    );

    always_comb begin
        clr_d = '0;
        for (int i = 0; i < NSRC; i++) begin
            if (accept && (win_idx == IDX_W'(i)) && (i < HWCLR_CNT)) begin
                clr_d[i] = 1'b1;
            end
        end
    end

    // state machine: next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (accept)  state_d = ST_CALL1;
            ST_CALL1: if (mc_tick) state_d = ST_CALL2;
            ST_CALL2: if (mc_tick) state_d = ST_IDLE;
            default:               state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ack_q <= 1'b0;
            src_q <= '0;
            vec_q <= '0;
            clr_q <= '0;
        end else begin
            ack_q <= accept;
            clr_q <= clr_d;
            if (accept) begin
                src_q <= win_idx;
                vec_q <= ADDR_W'(VEC_BASE) + ADDR_W'(VEC_STEP) * ADDR_W'(win_idx);
            end
        end
    end

    assign call_req  = (state_q != ST_IDLE);
    assign ack_valid = ack_q;
    assign ack_src   = src_q;
    assign vec_addr  = vec_q;
    assign flag_clr  = clr_q;

    AST_ACK_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> (ea_q && en_src_q[ack_src])); // R2
    AST_POLL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |-> $past(mc_tick && instr_last)); // R4
    AST_CALL_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(call_req) |-> ack_valid); // R8
    AST_ACK_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        ack_valid |=> !ack_valid); // R9
    AST_CLR_SCOPE: assert property (@(posedge clk) disable iff (!rst_n)
        (|flag_clr) |-> (ack_valid && (flag_clr == (NSRC'(1) << ack_src))
                         && (ack_src < IDX_W'(HWCLR_CNT)))); // R10
endmodule

// File: tb/sim_irq_vector_ctrl.sv
`timescale 1ns/1ps
module sim_irq_vector_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mc_tick = 1'b0, instr_last = 1'b0, reti_exec = 1'b0;
    logic        en_wr = 1'b0, pri_wr = 1'b0;
    logic [7:0]  en_wdata = '0, pri_wdata = '0;
    logic [5:0]  flags = '0;
    logic        call_req, ack_valid;
    logic [15:0] vec_addr;
    logic [2:0]  ack_src;
    logic [5:0]  flag_clr;
    logic [1:0]  svc_level;

    int n_checks = 0;
    int n_errs   = 0;

    // bench model state
    logic [5:0]  m_pend = '0, m_en = '0, m_pri = '0;
    logic        m_ea = 1'b0, m_blk = 1'b0;
    logic [1:0]  m_svc = '0;
    int          m_call = 0;
    int          m_vec = 0;

    always #2 clk = ~clk;

    irq_vector_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .mc_tick(mc_tick), .instr_last(instr_last),
        .reti_exec(reti_exec), .en_wr(en_wr), .en_wdata(en_wdata),
        .pri_wr(pri_wr), .pri_wdata(pri_wdata), .flag_in(flags),
        .call_req(call_req), .vec_addr(vec_addr), .ack_valid(ack_valid),
        .ack_src(ack_src), .flag_clr(flag_clr), .svc_level(svc_level)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int first_set(input logic [5:0] v);
        for (int i = 0; i < 6; i++) if (v[i]) return i;
        return 0;
    endfunction

    task automatic do_tick(input logic last, input logic reti, input logic enw,
                           input logic [7:0] enwd, input logic priw,
                           input logic [7:0] priwd, input string ctx);
        logic       special, ok, exp_ack;
        logic [5:0] elig, hi, lo, exp_clr;
        int         lvl, exp_src;
        @(negedge clk);
        mc_tick = 1'b1; instr_last = last; reti_exec = reti;
        en_wr = enw; en_wdata = enwd; pri_wr = priw; pri_wdata = priwd;
        exp_ack = 1'b0; exp_clr = '0; exp_src = 0; lvl = 0;
        if (m_call == 0) begin
            special = reti | enw | priw;
            ok      = last && !special && !m_blk;
            elig    = m_pend & m_en & {6{m_ea}};
            hi      = elig & m_pri;
            lo      = elig & ~m_pri;
            if (ok && !m_svc[1] && hi != 0) begin
                exp_ack = 1'b1; exp_src = first_set(hi); lvl = 1;
            end else if (ok && m_svc == 2'b00 && lo != 0) begin
                exp_ack = 1'b1; exp_src = first_set(lo); lvl = 0;
            end
            if (last) m_blk = special;
            if (last && reti) begin
                if (m_svc[1]) m_svc[1] = 1'b0; else m_svc[0] = 1'b0;
            end
            if (exp_ack) begin
                m_svc[lvl] = 1'b1;
                m_call = 2;
                m_vec = 3 + 8 * exp_src;
                if (exp_src < 4) exp_clr = 6'(1 << exp_src);
            end
        end else begin
            m_call--;
        end
        if (enw) begin m_en = enwd[5:0]; m_ea = enwd[7]; end
        if (priw) m_pri = priwd[5:0];
        m_pend = flags;
        @(negedge clk);
        chk(ack_valid === exp_ack, {ctx, " R9"}, "ack_valid", int'(ack_valid), int'(exp_ack));
        if (exp_ack) chk(ack_src == 3'(exp_src), {ctx, " R5"}, "ack_src", int'(ack_src), exp_src);
        chk(call_req === (m_call != 0), {ctx, " R8"}, "call_req", int'(call_req), int'(m_call != 0));
        if (m_call != 0) chk(vec_addr == 16'(m_vec), {ctx, " R8"}, "vec_addr", int'(vec_addr), m_vec);
        chk(flag_clr == exp_clr, {ctx, " R10"}, "flag_clr", int'(flag_clr), int'(exp_clr));
        chk(svc_level == m_svc, {ctx, " R6 R7"}, "svc_level", int'(svc_level), int'(m_svc));
        flags = flags & ~exp_clr;
        mc_tick = 1'b0; reti_exec = 1'b0; en_wr = 1'b0; pri_wr = 1'b0;
        @(negedge clk);
        chk(ack_valid == 1'b0 && flag_clr == '0, {ctx, " R9"}, "pulse width",
            int'({ack_valid, flag_clr}), 0);
    endtask

    task automatic run(input int n, input string ctx);
        for (int k = 0; k < n; k++) do_tick(1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, ctx);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++; n_errs++;
        $display("FAIL R8 watchdog: actual running expected finished");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(call_req == 0 && ack_valid == 0 && flag_clr == 0, "R1", "outputs",
            int'({call_req, ack_valid, flag_clr}), 0);
        chk(vec_addr == 16'h0000, "R1", "vec_addr", int'(vec_addr), 0);
        chk(svc_level == 2'b00, "R1", "svc_level", int'(svc_level), 0);

        // R2: enabled source without global enable never calls
        do_tick(1, 0, 1, 8'h01, 0, 8'h00, "R2 no-global");
        flags = 6'h01;
        run(3, "R2 blocked");
        do_tick(1, 0, 1, 8'h81, 0, 8'h00, "R2 global-on");
        run(2, "R2 accept");
        // R11: return and final cycle during the call have no effect
        do_tick(1, 1, 0, 8'h00, 0, 8'h00, "R11 in-call");
        do_tick(1, 1, 0, 8'h00, 0, 8'h00, "R11 in-call");
        do_tick(1, 1, 0, 8'h00, 0, 8'h00, "R7 return");
        do_tick(1, 0, 0, 8'h00, 0, 8'h00, "R4 after-return");
        // R3: one machine cycle between sampling and polling
        flags = 6'h10;
        do_tick(1, 0, 1, 8'h93, 0, 8'h00, "R3 enable");
        do_tick(1, 0, 0, 8'h00, 0, 8'h00, "R3 sample");
        do_tick(1, 0, 0, 8'h00, 0, 8'h00, "R3 poll");
        run(2, "R8 call");
        // R6: high preempts low, serial flag not cleared (R10)
        flags = 6'h03;
        do_tick(1, 0, 0, 8'h00, 1, 8'h02, "R6 prio-write");
        do_tick(0, 0, 0, 8'h00, 0, 8'h00, "R4 mid-instr");
        run(6, "R6 nest");
        do_tick(1, 1, 0, 8'h00, 0, 8'h00, "R7 return-hi");
        run(4, "R6 after");
        do_tick(1, 1, 0, 8'h00, 0, 8'h00, "R7 return-lo");
        do_tick(1, 1, 0, 8'h00, 0, 8'h00, "R7 return-lo");
        flags = '0;
        run(3, "R5 drain");

        for (int k = 0; k < 3000; k++) begin
            logic [7:0] ed, pd;
            if ($urandom % 4 == 0) flags = flags | 6'(1 << ($urandom % 6));
            if ($urandom % 6 == 0) flags[5:4] = 2'b00;
            ed = {($urandom % 8 != 0) ? 1'b1 : 1'b0, 1'b0, 6'($urandom)};
            pd = 8'($urandom);
            do_tick(($urandom % 2) == 0, ($urandom % 8) == 0, ($urandom % 32) == 0, ed,
                    ($urandom % 32) == 0, pd, "random R2 R4");
        end

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end
endmodule